// File: doc/BRIEF.md
# Eight-Channel DMA Channel Allocator

This block hands out DMA channels to requesters and takes them back. It holds a usage bitmap with one bit per channel (1 = in use) and serves one request at a time through a request/busy/done handshake. A requester can claim a named channel, claim with a preferred channel and an allowed-channel mask, release a channel, or ask whether a channel is taken. It can also ask for the data-bus width that belongs to a channel number. Numbers that are not valid channels are reported through the error flag.

A claim with preference takes the preferred channel when it is valid and free. Otherwise a scan walks upward from channel 0, one channel per clock, and grants the first channel that is both enabled in the mask and free. Channel 4 is taken at reset as the cascade link between the two halves of the controller pair, and no request can free it. The bitmap is written only at the end of the cycle in which `done_o` is high, so a result and the map it was decided on always agree.

Top module: `dma_chan_alloc`

## Requirements
- R1: After reset `busy_o` and `done_o` are low and the only channel marked in use is channel 4; all others read as free.
- R2: Opcode 0 (direct claim) on a valid, free channel returns the channel number with `err_o` low and marks it used; on a used or invalid channel (8 or above) it returns all ones (255) with `err_o` high and leaves the map unchanged.
- R3: Opcode 2 (release) on a valid channel other than 4 returns the channel number with `err_o` low and marks it free; for channel 4 or a number of 8 or above it returns 255 with `err_o` high and changes nothing.
- R4: Opcode 3 (query) returns 1 for a used channel and 0 for a free one; for a number of 8 or above it returns 0 with `err_o` high.
- R5: Opcode 4 (width) returns 8 for channels 0 to 3 and 16 for channels 4 to 7; for 8 or above it returns 0 with `err_o` high.
- R6: Opcode 1 (claim with preference) whose preferred channel is valid and free grants that channel and marks it used, with `done_o` on the first rising edge after acceptance.
- R7: When the preferred channel is invalid or used, opcode 1 grants the lowest channel k whose mask bit is 1 and which is free, marks it used, and raises `done_o` on rising edge k+2 after acceptance.
- R8: When no channel qualifies, opcode 1 returns 255 with `err_o` high, changes nothing, and raises `done_o` on rising edge 9 after acceptance.
- R9: A request is accepted on a rising edge where `req_i` is high and `busy_o` low; `busy_o` is high from the next cycle through the `done_o` cycle, `done_o` is high for exactly one cycle, and every opcode other than a scanning claim finishes on the first rising edge after acceptance.
- R10: A request raised while `busy_o` is high is ignored and leaves the map unchanged.
- R11: Opcodes 5 to 7 return 255 with `err_o` high, change nothing, and finish on the first rising edge after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, taken when busy_o is low |
| op_i | input | 3 | Opcode: 0 claim, 1 claim with preference, 2 release, 3 query, 4 width |
| chan_i | input | 4 | Channel number or preferred channel |
| mask_i | input | 8 | Channels allowed for the fallback scan |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse; result_o and err_o valid |
| result_o | output | 8 | Granted channel, query bit, bus width, or 255 |
| err_o | output | 1 | Request failed or channel number invalid |

## Verification
Every result is due a fixed number of rising edges after acceptance: one for all direct operations and a preferred-channel hit, k+2 for a scan that grants channel k, and nine for a scan that finds nothing. The bench drives on falling edges, counts falling edges from the accepting edge until `done_o` appears, and compares that count, the result and the error flag with a bitmap model of its own; it then checks on the next falling edge that `done_o` has dropped and `busy_o` is low. Channel sweeps cover every number from 0 to 15 for each direct opcode, and preference claims run against many occupancy and mask patterns, including an empty mask and a request injected mid-scan.

// File: rtl/dma_alloc_pkg.sv
package dma_alloc_pkg;

  localparam logic [2:0] OP_CLAIM      = 3'd0;
  localparam logic [2:0] OP_CLAIM_PREF = 3'd1;
  localparam logic [2:0] OP_RELEASE    = 3'd2;
  localparam logic [2:0] OP_QUERY      = 3'd3;
  localparam logic [2:0] OP_WIDTH      = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_SCAN = 2'd2,
    ST_DONE = 2'd3
  } alloc_st_e;

endpackage

// File: rtl/dma_alloc_map.sv
module dma_alloc_map #(
  parameter int unsigned NCH    = 8,
  parameter int unsigned RSV_CH = 4,
  localparam int unsigned IDX_W = $clog2(NCH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic             set_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [NCH-1:0]   map_o
);

  logic [NCH-1:0] map_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q <= NCH'(1) << RSV_CH;
    end else if (commit_i) begin
      map_q[idx_i] <= set_i;
    end
  end

  assign map_o = map_q;

  // reserved link channel must never be released through a commit
  p_rsv_held_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && int'(idx_i) == RSV_CH) |-> set_i);

endmodule

// File: rtl/dma_alloc_scan.sv
module dma_alloc_scan #(
  parameter int unsigned NCH    = 8,
  localparam int unsigned IDX_W = $clog2(NCH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (start_i) idx_q <= '0;
    else if (step_i)  idx_q <= idx_q + 1'b1;
  end

  assign idx_o  = idx_q;
  assign last_o = (int'(idx_q) == NCH - 1);

  // scan never steps past the last channel (bounds claim latency, R8)
  p_no_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !start_i) |=> (idx_q != '0));

endmodule

// File: rtl/dma_chan_alloc.sv
module dma_chan_alloc
  import dma_alloc_pkg::*;
#(
  parameter int unsigned NCH        = 8,
  parameter int unsigned CH_W       = 4,
  parameter int unsigned RES_W      = 8,
  parameter int unsigned RSV_CH     = 4,
  parameter int unsigned NARROW_CNT = 4,
  parameter int unsigned NARROW_W   = 8,
  parameter int unsigned WIDE_W     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [2:0]       op_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic [NCH-1:0]   mask_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o,
  output logic             err_o
);

  localparam int unsigned IDX_W = $clog2(NCH);
  localparam logic [RES_W-1:0] RES_NONE = '1;

  alloc_st_e        st_q, st_d;
  logic [2:0]       op_q;
  logic [CH_W-1:0]  chan_q;
  logic [NCH-1:0]   mask_q;
  logic [RES_W-1:0] res_q, res_d;
  logic             err_q, err_d;
  logic             wr_q, wr_d, wr_set_q, wr_set_d;
  logic [IDX_W-1:0] wr_idx_q, wr_idx_d;

  logic [NCH-1:0]   map_w;
  logic [IDX_W-1:0] scan_idx;
  logic             scan_last, scan_start, scan_step;
  logic             chan_ok, chan_free, scan_hit;
  logic [IDX_W-1:0] chan_idx;

  assign chan_idx  = chan_q[IDX_W-1:0];
  assign chan_ok   = (int'(chan_q) < NCH);
  assign chan_free = chan_ok && !map_w[chan_idx];
  assign scan_hit  = mask_q[scan_idx] && !map_w[scan_idx];

  dma_alloc_map #(.NCH(NCH), .RSV_CH(RSV_CH)) u_map (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .commit_i(st_q == ST_DONE && wr_q),
    .set_i   (wr_set_q),
    .idx_i   (wr_idx_q),
    .map_o   (map_w)
  );

  dma_alloc_scan #(.NCH(NCH)) u_scan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(scan_start),
    .step_i (scan_step),
    .idx_o  (scan_idx),
    .last_o (scan_last)
  );

  assign scan_start = (st_q == ST_EXEC);
  assign scan_step  = (st_q == ST_SCAN) && !scan_hit && !scan_last;

  always_comb begin
    st_d     = st_q;
    res_d    = res_q;
    err_d    = err_q;
    wr_d     = wr_q;
    wr_set_d = wr_set_q;
    wr_idx_d = wr_idx_q;
    unique case (st_q)
      ST_IDLE: begin
        if (req_i) st_d = ST_EXEC;
      end
      ST_EXEC: begin
        st_d     = ST_DONE;
        res_d    = RES_NONE;
        err_d    = 1'b1;
        wr_d     = 1'b0;
        wr_set_d = 1'b0;
        wr_idx_d = chan_idx;
        case (op_q)
          OP_CLAIM, OP_CLAIM_PREF: begin
            if (chan_free) begin
              res_d    = RES_W'(chan_q);
              err_d    = 1'b0;
              wr_d     = 1'b1;
              wr_set_d = 1'b1;
            end else if (op_q == OP_CLAIM_PREF) begin
              st_d = ST_SCAN;
            end
          end
          OP_RELEASE: begin
            if (chan_ok && int'(chan_q) != RSV_CH) begin
              res_d = RES_W'(chan_q);
              err_d = 1'b0;
              wr_d  = 1'b1;
            end
          end
          OP_QUERY: begin
            res_d = '0;
            if (chan_ok) begin
              res_d = RES_W'(map_w[chan_idx]);
              err_d = 1'b0;
            end
          end
          OP_WIDTH: begin
            res_d = '0;
            if (chan_ok) begin
              res_d = (int'(chan_q) < NARROW_CNT) ? RES_W'(NARROW_W) : RES_W'(WIDE_W);
              err_d = 1'b0;
            end
          end
          default: ;
        endcase
      end
      ST_SCAN: begin
        if (scan_hit) begin
          st_d     = ST_DONE;
          res_d    = RES_W'(scan_idx);
          err_d    = 1'b0;
          wr_d     = 1'b1;
          wr_set_d = 1'b1;
          wr_idx_d = scan_idx;
        end else if (scan_last) begin
          st_d = ST_DONE;
        end
      end
      ST_DONE: begin
        st_d = ST_IDLE;
        wr_d = 1'b0;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      op_q     <= '0;
      chan_q   <= '0;
      mask_q   <= '0;
      res_q    <= '0;
      err_q    <= 1'b0;
      wr_q     <= 1'b0;
      wr_set_q <= 1'b0;
      wr_idx_q <= '0;
    end else begin
      st_q     <= st_d;
      res_q    <= res_d;
      err_q    <= err_d;
      wr_q     <= wr_d;
      wr_set_q <= wr_set_d;
      wr_idx_q <= wr_idx_d;
      if (st_q == ST_IDLE && req_i) begin
        op_q   <= op_i;
        chan_q <= chan_i;
        mask_q <= mask_i;
      end
    end
  end

  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = (st_q == ST_DONE);
  assign result_o = res_q;
  assign err_o    = err_q;

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_in_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  p_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i) |=> busy_o);

  p_map_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> $stable(map_w));

  p_claim_free_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o && (op_q == OP_CLAIM || op_q == OP_CLAIM_PREF))
      |-> !map_w[result_o[IDX_W-1:0]]);

  p_fail_ones_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o && op_q == OP_CLAIM_PREF) |-> (result_o == RES_NONE));

  p_width_val_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_WIDTH && !err_o)
      |-> (result_o == RES_W'(NARROW_W) || result_o == RES_W'(WIDE_W)));

  p_rsv_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_RELEASE && int'(chan_q) == RSV_CH) |-> err_o);

endmodule

// File: tb/sim_dma_chan_alloc.sv
module sim_dma_chan_alloc;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [2:0] op = '0;
  logic [3:0] chan = '0;
  logic [7:0] mask = '0;
  logic       busy, done, err;
  logic [7:0] result;

  int checks = 0;
  int errors = 0;
  bit [7:0] mm;
  bit       finished = 0;

  always #2.5 clk = ~clk;

  dma_chan_alloc u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .chan_i(chan),
    .mask_i(mask), .busy_o(busy), .done_o(done), .result_o(result), .err_o(err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // bench model of the specified behaviour
  task automatic model(input logic [2:0] o, input int ch, input logic [7:0] m,
                       output int res, output int er, output int lat, output string tag);
    lat = 1; er = 0; res = 255;
    case (o)
      3'd0: begin
        tag = "R2";
        if (ch < 8 && !mm[ch]) begin res = ch; mm[ch] = 1; end
        else er = 1;
      end
      3'd1: begin
        if (ch < 8 && !mm[ch]) begin res = ch; mm[ch] = 1; tag = "R6"; end
        else begin
          er = 1; lat = 9; tag = "R8";
          for (int k = 0; k < 8; k++) begin
            if (m[k] && !mm[k]) begin
              res = k; er = 0; lat = k + 2; mm[k] = 1; tag = "R7";
              break;
            end
          end
        end
      end
      3'd2: begin
        tag = "R3";
        if (ch < 8 && ch != 4) begin res = ch; mm[ch] = 0; end
        else er = 1;
      end
      3'd3: begin
        tag = "R4";
        if (ch < 8) res = int'(mm[ch]);
        else begin res = 0; er = 1; end
      end
      3'd4: begin
        tag = "R5";
        if (ch < 8) res = (ch < 4) ? 8 : 16;
        else begin res = 0; er = 1; end
      end
      default: begin tag = "R11"; er = 1; end
    endcase
  endtask

  task automatic run(input logic [2:0] o, input int ch, input logic [7:0] m, input bit inject);
    int res, er, lat, seen;
    string tag;
    model(o, ch, m, res, er, lat, tag);
    @(negedge clk);
    req = 1'b1; op = o; chan = 4'(ch); mask = m;
    @(negedge clk);
    req = 1'b0;
    chk("R9 busy after accept", int'(busy), 1);
    seen = 1;
    while (!done && seen < 30) begin
      if (inject && seen == 3) begin
        req = 1'b1; op = 3'd0; chan = 4'd0; mask = 8'hFF;  // R10 stray request
      end else begin
        req = 1'b0;
      end
      @(negedge clk);
      seen++;
    end
    req = 1'b0;
    chk({tag, " latency"}, seen - 1, lat);
    chk({tag, " result"}, int'(result), res);
    chk({tag, " error"}, int'(err), er);
    @(negedge clk);
    chk("R9 done single cycle", int'(done), 0);
    chk("R9 busy released", int'(busy), 0);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected < 100000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    mm = 8'h10;
    repeat (3) @(negedge clk);
    chk("R1 busy at reset", int'(busy), 0);
    chk("R1 done at reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);

    // R1 / R4: reset map via queries over all numbers
    for (int c = 0; c < 16; c++) run(3'd3, c, 8'h00, 0);
    // R5: width sweep
    for (int c = 0; c < 16; c++) run(3'd4, c, 8'h00, 0);
    // R11: undefined opcodes
    for (int o = 5; o < 8; o++) run(3'(o), o - 4, 8'hFF, 0);
    // R2: direct claims, then repeats on used channels
    for (int c = 0; c < 16; c++) run(3'd0, c, 8'h00, 0);
    run(3'd0, 2, 8'h00, 0);
    for (int c = 0; c < 8; c++) run(3'd3, c, 8'h00, 0);
    // R3: releases including reserved and invalid numbers
    for (int c = 0; c < 16; c++) run(3'd2, c, 8'h00, 0);
    for (int c = 0; c < 8; c++) run(3'd3, c, 8'h00, 0);

    // R6 / R7 / R8: preference claims over occupancy and mask patterns
    for (int p = 0; p < 40; p++) begin
      logic [7:0] occ, msk;
      int pref;
      occ  = 8'((p * 37 + 5) & 8'hEF);
      msk  = (p % 7 == 0) ? 8'h00 : ((p % 5 == 0) ? 8'hFF : 8'((p * 91 + 13)));
      pref = (p * 3) % 11;
      for (int c = 0; c < 8; c++) if (occ[c]) run(3'd0, c, 8'h00, 0);
      run(3'd1, pref, msk, 0);
      for (int c = 0; c < 8; c++) run(3'd3, c, 8'h00, 0);
      for (int c = 0; c < 8; c++) if (c != 4 && mm[c]) run(3'd2, c, 8'h00, 0);
    end

    // R8: everything used, full mask
    for (int c = 0; c < 8; c++) run(3'd0, c, 8'h00, 0);
    run(3'd1, 1, 8'hFF, 0);
    for (int c = 0; c < 8; c++) run(3'd2, c, 8'h00, 0);

    // R10: stray claim of channel 0 during a long scan is ignored
    run(3'd1, 4, 8'h80, 1);
    run(3'd3, 0, 8'h00, 0);
    run(3'd3, 7, 8'h00, 0);
    run(3'd2, 7, 8'h00, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule